// File: doc/BRIEF.md
# AC Load Tweeter Presence Qualifier

This block decides, for each amplifier channel, whether a capacitively coupled tweeter is still connected. During a diagnostic tone, an analog comparator raises a strobe whenever the output current peaks above the high threshold (500 mA). A second comparator reports when the current stays below the low threshold (250 mA). The block counts qualifying high-current pulses inside a measuring window. The window opens when the AC-diagnostic enable bit is set. It closes at the next host read of the diagnostic status.

At each read, a channel that collected at least three qualifying pulses reports the tweeter as present. Otherwise it reports it as open. A short-circuit protection event during a window spoils that window's measurement: the reported bit keeps its earlier value, and the read opens a fresh window anyway. Clearing the enable bit resets all counting and clears every reported bit. Tone generation and current sensing are handled elsewhere.

Top module: `acq_top`

## Requirements
- R1: After reset, every bit of `open_tw` is 0.
- R2: A qualifying pulse is a rising edge of `hi_cmp[c]`. A level held high for many cycles counts once.
- R3: The per-channel pulse count saturates at 3. Further pulses in the same window do not change the verdict.
- R4: When `rd_strobe` is high while `ac_en` is high and the closing window was not spoiled, `open_tw[c]` takes the value 1 if fewer than 3 qualifying pulses arrived in that window and 0 otherwise. The new value is visible from the cycle after the read. Without a read, `open_tw` does not change while enabled.
- R5: If `scp_act[c]` is high in any cycle of a window, including the read cycle, the read that closes the window leaves `open_tw[c]` at its previous value.
- R6: Every read while enabled starts a new window with a zero count and a cleared spoil flag. A qualifying edge in the read cycle itself is counted in the new window.
- R7: While `ac_en` is low, `open_tw` is 0 from the next cycle on. Pulses and reads have no effect, and the count restarts from zero once enabled.
- R8: A rising edge of `hi_cmp[c]` in a cycle where `lo_cmp[c]` is high does not count as a pulse.
- R9: Channels are independent. Pulses, protection events and verdicts on one channel do not affect another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ac_en | input | 1 | AC-diagnostic enable bit |
| rd_strobe | input | 1 | One-cycle pulse on each host read of the results |
| hi_cmp | input | NUM_CH | Current above the high threshold, one bit per channel |
| lo_cmp | input | NUM_CH | Current below the low threshold, one bit per channel |
| scp_act | input | NUM_CH | Short-circuit protection active, one bit per channel |
| open_tw | output | NUM_CH | Latched open-tweeter verdict, one bit per channel |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that `rd_strobe` is a single-cycle pulse. They make no assumption about the width or spacing of comparator strobes.

The bench changes inputs only on the falling clock edge and drives each read for exactly one cycle. It shapes comparator pulses as one-cycle or multi-cycle levels separated by low cycles. It also places edges, protection events and reads in the same cycle, so that coincident events are covered inside the assumed input envelope.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int unsigned DEF_NUM_CH  = 4;
  localparam int unsigned DEF_REQ_CNT = 3;

  typedef enum logic [1:0] {
    ACT_IDLE    = 2'd0,
    ACT_HOLD    = 2'd1,
    ACT_RESOLVE = 2'd2,
    ACT_CLEAR   = 2'd3
  } verdict_act_e;
endpackage

// File: rtl/acq_edge_qual.sv
module acq_edge_qual #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    prev_d = hi_i;
    edge_o = hi_i & ~prev_q & ~lo_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R2: a held level cannot produce two consecutive qualifying edges
    p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o[i] |=> !edge_o[i]);
  end
endmodule

// File: rtl/acq_pulse_cnt.sv
module acq_pulse_cnt #(
  parameter int unsigned REQ = 3,
  localparam int unsigned CW = $clog2(REQ + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic restart_i,
  input  logic inc_i,
  output logic met_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          sat;

  always_comb begin
    sat   = (cnt_q == CW'(REQ));
    cnt_d = cnt_q;
    if (!en_i)
      cnt_d = '0;
    else if (restart_i)
      cnt_d = inc_i ? CW'(1) : '0;
    else if (inc_i && !sat)
      cnt_d = cnt_q + CW'(1);
    met_o = sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: count never passes the saturation point
  p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(REQ));
  // R7: disabled channel has an empty count next cycle
  p_cnt_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
  // R6: a read restarts the count at zero or one
  p_cnt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && restart_i) |=> (cnt_q <= CW'(1)));
endmodule

// File: rtl/acq_verdict.sv
module acq_verdict
  import acq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic rd_i,
  input  logic scp_i,
  input  logic met_i,
  output logic open_o
);
  verdict_act_e act;
  logic spoil_q, spoil_d;
  logic res_q, res_d;

  always_comb begin
    if (!en_i)                 act = ACT_CLEAR;
    else if (rd_i && (spoil_q || scp_i)) act = ACT_HOLD;
    else if (rd_i)             act = ACT_RESOLVE;
    else                       act = ACT_IDLE;
  end

  always_comb begin
    spoil_d = spoil_q;
    res_d   = res_q;
    unique case (act)
      ACT_CLEAR: begin
        spoil_d = 1'b0;
        res_d   = 1'b0;
      end
      ACT_HOLD: begin
        spoil_d = 1'b0;
      end
      ACT_RESOLVE: begin
        spoil_d = 1'b0;
        res_d   = !met_i;
      end
      default: begin
        spoil_d = spoil_q | scp_i;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spoil_q <= 1'b0;
      res_q   <= 1'b0;
    end else begin
      spoil_q <= spoil_d;
      res_q   <= res_d;
    end
  end

  assign open_o = res_q;

  // R5: protection in the read cycle keeps the verdict
  p_abort_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && rd_i && scp_i) |=> $stable(open_o));
  // R7: disabling clears the verdict
  p_off_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !open_o);
  // R4: no read, no change while enabled
  p_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !rd_i) |=> $stable(open_o));
endmodule

// File: rtl/acq_top.sv
module acq_top #(
  parameter int unsigned NUM_CH  = acq_pkg::DEF_NUM_CH,
  parameter int unsigned REQ_CNT = acq_pkg::DEF_REQ_CNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ac_en,
  input  logic              rd_strobe,
  input  logic [NUM_CH-1:0] hi_cmp,
  input  logic [NUM_CH-1:0] lo_cmp,
  input  logic [NUM_CH-1:0] scp_act,
  output logic [NUM_CH-1:0] open_tw
);
  logic [NUM_CH-1:0] qual_edge;
  logic [NUM_CH-1:0] met;

  acq_edge_qual #(.W(NUM_CH)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .hi_i   (hi_cmp),
    .lo_i   (lo_cmp),
    .edge_o (qual_edge)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    acq_pulse_cnt #(.REQ(REQ_CNT)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (ac_en),
      .restart_i (rd_strobe),
      .inc_i     (qual_edge[c]),
      .met_o     (met[c])
    );

    acq_verdict u_vrd (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (ac_en),
      .rd_i   (rd_strobe),
      .scp_i  (scp_act[c]),
      .met_i  (met[c]),
      .open_o (open_tw[c])
    );
  end

  // R1: reported bits are zero straight out of reset
  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (open_tw == '0));
endmodule

// File: tb/acq_top_tb.sv
`timescale 1ns/1ps
module acq_top_tb;
  localparam int NCH = 4;
  localparam int REQ = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic ac_en, rd_strobe;
  logic [NCH-1:0] hi_cmp, lo_cmp, scp_act;
  logic [NCH-1:0] open_tw;

  always #2 clk = ~clk;

  acq_top #(.NUM_CH(NCH), .REQ_CNT(REQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .ac_en(ac_en), .rd_strobe(rd_strobe),
    .hi_cmp(hi_cmp), .lo_cmp(lo_cmp), .scp_act(scp_act), .open_tw(open_tw)
  );

  typedef struct {
    int             due;
    logic [NCH-1:0] exp;
    string          tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state derived from the requirements
  int             m_cnt[NCH];
  bit             m_spoil[NCH];
  logic [NCH-1:0] m_res;
  logic [NCH-1:0] m_prev_hi;
  bit             m_en;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop and compare expected items once due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (open_tw !== it.exp) begin
        bad++;
        $display("FAIL %s: open_tw actual=%b expected=%b at cycle %0d",
                 it.tag, open_tw, it.exp, cyc);
      end
    end
  end

  // driver: one cycle of stimulus, model update, expected push
  task automatic tick(input logic [NCH-1:0] hi, input logic [NCH-1:0] lo,
                      input logic [NCH-1:0] scp, input logic rd, input string tag);
    item_t it;
    @(negedge clk);
    hi_cmp = hi; lo_cmp = lo; scp_act = scp; rd_strobe = rd; ac_en = m_en;
    for (int c = 0; c < NCH; c++) begin
      bit e;
      e = hi[c] && !m_prev_hi[c] && !lo[c];          // R2, R8
      if (!m_en) begin                               // R7
        m_cnt[c] = 0; m_spoil[c] = 0; m_res[c] = 1'b0;
      end else if (rd) begin
        if (!(m_spoil[c] || scp[c]))                 // R5
          m_res[c] = (m_cnt[c] < REQ);               // R4
        m_cnt[c] = e ? 1 : 0;                        // R6
        m_spoil[c] = 0;
      end else begin
        if (e && m_cnt[c] < REQ) m_cnt[c]++;         // R3
        if (scp[c]) m_spoil[c] = 1;
      end
    end
    m_prev_hi = hi;
    it.due = cyc + 1; it.exp = m_res; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic pulses(input logic [NCH-1:0] m, input logic [NCH-1:0] lo,
                        input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick(m, lo, '0, 1'b0, tag);
      tick('0, '0, '0, 1'b0, tag);
    end
  endtask

  task automatic do_read(input logic [NCH-1:0] hi, input logic [NCH-1:0] scp,
                         input string tag);
    tick(hi, '0, scp, 1'b1, tag);
    tick('0, '0, '0, 1'b0, tag);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin m_cnt[c] = 0; m_spoil[c] = 0; end
    m_res = '0; m_prev_hi = '0; m_en = 0;
    rst_n = 1'b0; ac_en = 0; rd_strobe = 0;
    hi_cmp = '0; lo_cmp = '0; scp_act = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (open_tw !== '0) begin
      bad++;
      $display("FAIL R1: open_tw actual=%b expected=%b", open_tw, 4'b0000);
    end

    // window 1: ch0 3 pulses, ch1 2, ch2 5 (saturates), ch3 none
    m_en = 1;
    tick('0, '0, '0, 1'b0, "R7 enable");
    pulses(4'b0111, '0, 2, "R4 window1");
    pulses(4'b0101, '0, 1, "R4 window1");
    pulses(4'b0100, '0, 2, "R3 saturate");
    do_read('0, '0, "R4 R3 R9 read1 expect 1010");

    // window 2: held level on ch0, masked edges on ch1, spoiled ch2, ch3 3 pulses
    tick(4'b0001, '0, '0, 1'b0, "R2 held");
    for (int i = 0; i < 5; i++) tick(4'b0001, '0, '0, 1'b0, "R2 held");
    tick('0, '0, '0, 1'b0, "R2 held");
    pulses(4'b0010, 4'b0010, 3, "R8 masked");
    pulses(4'b1000, '0, 3, "R9 window2");
    tick('0, '0, 4'b0100, 1'b0, "R5 spoil");
    do_read('0, '0, "R2 R8 R5 read2 expect 0011");

    // window 3: edge on ch0 in the read cycle, scp on ch3 in the read cycle
    pulses(4'b0110, '0, 3, "R6 window3");
    do_read(4'b0001, 4'b1000, "R5 R6 read3 expect 0001");
    pulses(4'b0001, '0, 2, "R6 window4");
    pulses(4'b1000, '0, 3, "R6 window4");
    do_read('0, '0, "R6 read4 expect 0110");

    // disable: verdict cleared, pulses and reads ignored
    m_en = 0;
    tick('0, '0, '0, 1'b0, "R7 disable");
    pulses(4'b1110, '0, 3, "R7 ignored pulses");
    do_read('0, '0, "R7 ignored read");
    m_en = 1;
    tick('0, '0, '0, 1'b0, "R7 reenable");
    pulses(4'b0001, '0, 3, "R7 fresh count");
    do_read('0, '0, "R7 read5 expect 1110");
    repeat (3) tick('0, '0, '0, 1'b0, "R4 idle stable");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule